// File: doc/BRIEF.md
# Self-Healing Reference Read Barrier

This block sits beside a processor pipeline and runs the read barrier of a concurrent, relocating collector as a stalling hardware sequence rather than a trap. For each request it is handed a reference value together with the base and offset of the location that reference came from. It checks two things. The first is whether the reference points into a page that is being relocated. The second is whether the reference's top bit, its not-marked-through flag, disagrees with the current mark phase. Each check that fires starts its own repair, and the repaired reference is written back over the stale copy so that the same location does not trigger the barrier again.

A barrier request heals memory. When the mark flag is wrong, the reference is handed to the buffer that feeds the marking engine, the flag is flipped, and the result is stored at base plus offset. When the page is protected, the old address goes out on a relocation port and the unit waits for the new address, which is then stored back to the same location. An ordinary load or store that faults on a protected page takes the relocation path only, and its result is handed back for the pipeline to write into the base register. A small table of protected page numbers decides what counts as protected.

Top module: `rb_heal_unit`

## Requirements
- R1: After reset the unit is idle (`busy`=0, `req_ready`=1), every protection table entry is cleared, and `mb_valid`, `mem_wr_valid`, `rel_req_valid` and `done` are all 0.
- R2: A barrier request (`req_kind`=0) that has bit W-1 of `req_ref` equal to `mark_phase` and is not in a protected page raises `done` exactly 2 cycles after it is accepted, with `done_healed`=0 and `done_ref`=`req_ref`. No mark, memory or relocation transfer occurs.
- R3: A barrier reference whose bit W-1 differs from `mark_phase` is offered on `mb_ref` with bit W-1 inverted and the other bits unchanged. It stays stable on `mb_valid` until `mb_ready` is seen.
- R4: After a repair of a barrier, exactly one memory write of the final reference goes to address (`req_base`+`req_offset`) mod 2^W and is held until `mem_wr_ready`. `done` then follows with `done_healed`=1 and `done_ref` equal to the written value.
- R5: A barrier issued again with the value that was written back produces no mark, memory or relocation transfer in the same phase. If `mark_phase` has changed, it triggers the mark path again.
- R6: A reference is protected when bits [W-2:PAGE_SH] match the page number of a valid table entry. In that case `rel_req_addr`=bits [W-2:0] of the reference is held on `rel_req_valid` until `rel_req_ready`. The unit then stays busy until `rel_rsp_valid`.
- R7: The reference after relocation keeps its original bit W-1, and its bits [W-2:0] are taken from `rel_rsp_addr`.
- R8: When a barrier needs both repairs, the relocation handshake completes before the mark hand-off. The mark check is then applied to the relocated reference, and a single memory write carries the final value.
- R9: An access-fault request (`req_kind`=1) takes only the relocation path. It never produces a mark or memory transfer, its bit W-1 is ignored, and `done_ref` carries the relocated value with `done_healed`=1 when the page was protected, or the unchanged value with `done_healed`=0 when it was not.
- R10: `busy` is 1 from the cycle after acceptance until `done` has been shown. A request presented while busy is neither accepted nor queued.
- R11: A table write with `prot_on`=1 sets entry `prot_idx` to page `prot_page`. A write with `prot_on`=0 clears that entry, after which its page no longer triggers relocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_phase | input | 1 | Expected value of the not-marked-through flag |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 1 | 0 = barrier (heal memory), 1 = access fault (heal register) |
| req_ref | input | W | Loaded reference, or base register value for a fault |
| req_base | input | W | Base address of the source location |
| req_offset | input | W | Offset added to the base |
| req_ready | output | 1 | Unit can accept a request |
| busy | output | 1 | A sequence is in progress |
| prot_wr | input | 1 | Protection table write strobe |
| prot_idx | input | IW | Table entry to write |
| prot_page | input | PN | Page number to store |
| prot_on | input | 1 | 1 sets the entry valid, 0 clears it |
| mb_valid | output | 1 | Reference offered to the mark buffer |
| mb_ref | output | W | Flag-corrected reference for marking |
| mb_ready | input | 1 | Mark buffer accepts |
| mem_wr_valid | output | 1 | Heal write request |
| mem_wr_addr | output | W | Heal write address |
| mem_wr_data | output | W | Healed reference |
| mem_wr_ready | input | 1 | Memory accepts the write |
| rel_req_valid | output | 1 | Relocation lookup request |
| rel_req_addr | output | W-1 | Old address |
| rel_req_ready | input | 1 | Relocation port accepts |
| rel_rsp_valid | input | 1 | New address available |
| rel_rsp_addr | input | W-1 | New address |
| done | output | 1 | One-cycle completion pulse |
| done_ref | output | W | Final reference value |
| done_healed | output | 1 | A repair was made |

## Verification
The hardest situation to reach is the double repair, where a protected reference also carries a stale flag. The relocation result has to feed the mark check, and memory must be written once, not twice. The stimulus reaches it by loading a page into the table and then issuing a barrier whose flag is opposite to the phase. Recorded handshake cycles confirm that the relocation came before the mark hand-off. A second hard case is a request that arrives while the unit is stalled. The bench holds the mark buffer back and keeps driving a different request throughout the stall, then checks that only the original reference was healed and that the unit goes idle afterwards.

// File: rtl/rb_heal_unit.sv
module rb_heal_unit #(
  parameter int W       = 32,
  parameter int PAGE_SH = 12,
  parameter int NPROT   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mark_phase,
  input  logic                          req_valid,
  input  logic                          req_kind,
  input  logic [W-1:0]                  req_ref,
  input  logic [W-1:0]                  req_base,
  input  logic [W-1:0]                  req_offset,
  output logic                          req_ready,
  output logic                          busy,
  input  logic                          prot_wr,
  input  logic [$clog2(NPROT)-1:0]      prot_idx,
  input  logic [W-2-PAGE_SH:0]          prot_page,
  input  logic                          prot_on,
  output logic                          mb_valid,
  output logic [W-1:0]                  mb_ref,
  input  logic                          mb_ready,
  output logic                          mem_wr_valid,
  output logic [W-1:0]                  mem_wr_addr,
  output logic [W-1:0]                  mem_wr_data,
  input  logic                          mem_wr_ready,
  output logic                          rel_req_valid,
  output logic [W-2:0]                  rel_req_addr,
  input  logic                          rel_req_ready,
  input  logic                          rel_rsp_valid,
  input  logic [W-2:0]                  rel_rsp_addr,
  output logic                          done,
  output logic [W-1:0]                  done_ref,
  output logic                          done_healed
);
  localparam int PN = W - 1 - PAGE_SH;
  localparam int IW = $clog2(NPROT);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_REL_REQ, S_REL_WAIT, S_MARK, S_WB, S_DONE
  } state_t;

  state_t          state;
  logic            kind_q;
  logic [W-1:0]    ref_q;
  logic [W-1:0]    src_q;
  logic            moved_q;
  logic            healed_q;
  logic [NPROT-1:0] pg_vld;
  logic [PN-1:0]   pg_num [NPROT];
  logic            prot_hit;
  logic            flag_bad;

  always_comb begin
    prot_hit = 1'b0;
    for (int i = 0; i < NPROT; i++)
      if (pg_vld[i] && pg_num[i] == ref_q[W-2:PAGE_SH]) prot_hit = 1'b1;
  end

  assign flag_bad = !kind_q && (ref_q[W-1] != mark_phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_vld <= '0;
      for (int i = 0; i < NPROT; i++) pg_num[i] <= '0;
    end else if (prot_wr) begin
      pg_vld[prot_idx] <= prot_on;
      pg_num[prot_idx] <= prot_page;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind_q   <= 1'b0;
      ref_q    <= '0;
      src_q    <= '0;
      moved_q  <= 1'b0;
      healed_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          kind_q   <= req_kind;
          ref_q    <= req_ref;
          src_q    <= req_base + req_offset;
          moved_q  <= 1'b0;
          healed_q <= 1'b0;
          state    <= S_CHECK;
        end
        S_CHECK: begin
          if (!moved_q && prot_hit)      state <= S_REL_REQ;
          else if (flag_bad)             state <= S_MARK;
          else if (!kind_q && healed_q)  state <= S_WB;
          else                           state <= S_DONE;
        end
        S_REL_REQ: if (rel_req_ready) state <= S_REL_WAIT;
        S_REL_WAIT: if (rel_rsp_valid) begin
          ref_q    <= {ref_q[W-1], rel_rsp_addr};
          moved_q  <= 1'b1;
          healed_q <= 1'b1;
          state    <= S_CHECK;
        end
        S_MARK: if (mb_ready) begin
          ref_q[W-1] <= ~ref_q[W-1];
          healed_q   <= 1'b1;
          state      <= S_WB;
        end
        S_WB: if (mem_wr_ready) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state != S_IDLE);
  assign req_ready     = !busy;
  assign mb_valid      = (state == S_MARK);
  assign mb_ref        = {~ref_q[W-1], ref_q[W-2:0]};
  assign mem_wr_valid  = (state == S_WB);
  assign mem_wr_addr   = src_q;
  assign mem_wr_data   = ref_q;
  assign rel_req_valid = (state == S_REL_REQ);
  assign rel_req_addr  = ref_q[W-2:0];
  assign done          = (state == S_DONE);
  assign done_ref      = ref_q;
  assign done_healed   = healed_q;

  logic unused_iw;
  assign unused_iw = (IW > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/rb_heal_unit_chk.sv
module rb_heal_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         busy,
  input logic         mb_valid,
  input logic [W-1:0] mb_ref,
  input logic         mb_ready,
  input logic         mem_wr_valid,
  input logic [W-1:0] mem_wr_addr,
  input logic [W-1:0] mem_wr_data,
  input logic         mem_wr_ready,
  input logic         rel_req_valid,
  input logic [W-2:0] rel_req_addr,
  input logic         rel_req_ready,
  input logic         done
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mb_valid || mem_wr_valid || rel_req_valid || done));

  assert_mb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_valid && !mb_ready) |=> (mb_valid && $stable(mb_ref)));

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mb_valid, mem_wr_valid, rel_req_valid, done}));

  assert_rel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req_valid && !rel_req_ready) |=> (rel_req_valid && $stable(rel_req_addr)));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind rb_heal_unit rb_heal_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .mb_valid(mb_valid), .mb_ref(mb_ref), .mb_ready(mb_ready),
  .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready),
  .rel_req_valid(rel_req_valid), .rel_req_addr(rel_req_addr),
  .rel_req_ready(rel_req_ready), .done(done)
);

// File: tb/rb_heal_unit_tb_top.sv
module rb_heal_unit_tb_top;
  localparam int W = 32, PAGE_SH = 12, NPROT = 4;
  localparam int PN = W - 1 - PAGE_SH, IW = $clog2(NPROT);

  logic clk = 0, rst_n = 0, mark_phase = 1;
  logic req_valid = 0, req_kind = 0;
  logic [W-1:0] req_ref = '0, req_base = '0, req_offset = '0;
  logic req_ready, busy;
  logic prot_wr = 0, prot_on = 0;
  logic [IW-1:0] prot_idx = '0;
  logic [PN-1:0] prot_page = '0;
  logic mb_valid, mb_ready = 0;
  logic [W-1:0] mb_ref;
  logic mem_wr_valid, mem_wr_ready = 0;
  logic [W-1:0] mem_wr_addr, mem_wr_data;
  logic rel_req_valid, rel_req_ready = 0, rel_rsp_valid = 0;
  logic [W-2:0] rel_req_addr, rel_rsp_addr = '0;
  logic done, done_healed;
  logic [W-1:0] done_ref;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  rb_heal_unit #(.W(W), .PAGE_SH(PAGE_SH), .NPROT(NPROT)) dut_i (.*);

  int n_mb, n_wr, n_rel, mb_wait, mb_it, rel_it, cyc, busy_bad;
  logic [W-1:0] r_mb, r_wa, r_wd, r_done;
  logic [W-2:0] r_rel;
  logic r_healed, r_fin;

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_page(input int idx, input logic [PN-1:0] pg, input logic on);
    @(negedge clk);
    prot_wr = 1; prot_idx = IW'(idx); prot_page = pg; prot_on = on;
    @(negedge clk);
    prot_wr = 0;
  endtask

  task automatic run_op(input logic kind, input logic [W-1:0] rf, input logic [W-1:0] base,
                        input logic [W-1:0] off, input logic [W-2:0] rsp, input int stall,
                        input logic intrude);
    int mbc, wrc, relc, rspc;
    logic relp;
    n_mb = 0; n_wr = 0; n_rel = 0; mb_wait = 0; mb_it = 0; rel_it = 0; cyc = 0;
    busy_bad = 0; r_fin = 0; r_healed = 0;
    r_mb = '0; r_wa = '0; r_wd = '0; r_done = '0; r_rel = '0;
    mbc = 0; wrc = 0; relc = 0; rspc = 0; relp = 0;
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_ref = rf; req_base = base; req_offset = off;
    @(negedge clk);
    if (intrude) begin
      req_kind = 0; req_ref = 32'h0000_0BAD; req_base = 32'h9000; req_offset = 0;
    end else req_valid = 0;
    for (int it = 1; it <= 60 && !r_fin; it++) begin
      mb_ready = 0; mem_wr_ready = 0; rel_req_ready = 0; rel_rsp_valid = 0;
      if (intrude && busy && req_ready) busy_bad++;
      if (done) begin
        r_fin = 1; cyc = it; r_done = done_ref; r_healed = done_healed; req_valid = 0;
      end
      if (mb_valid) begin
        mbc++; r_mb = mb_ref;
        if (mbc > stall) begin mb_ready = 1; n_mb++; mb_wait = mbc; mb_it = it; mbc = 0; end
      end
      if (mem_wr_valid) begin
        wrc++; r_wa = mem_wr_addr; r_wd = mem_wr_data;
        if (wrc > stall) begin mem_wr_ready = 1; n_wr++; wrc = 0; end
      end
      if (rel_req_valid) begin
        relc++; r_rel = rel_req_addr;
        if (relc > stall) begin rel_req_ready = 1; n_rel++; rel_it = it; relc = 0; relp = 1; rspc = 0; end
      end else if (relp) begin
        rspc++;
        if (rspc > stall) begin rel_rsp_valid = 1; rel_rsp_addr = rsp; relp = 0; end
      end
      if (!r_fin) @(negedge clk);
    end
    @(negedge clk);
    mb_ready = 0; mem_wr_ready = 0; rel_req_ready = 0; rel_rsp_valid = 0;
  endtask

  task automatic t_reset;
    chk(!busy && req_ready, "R1 idle after reset", {30'd0, busy, req_ready}, 32'd1);
    chk(!mb_valid && !mem_wr_valid && !rel_req_valid && !done, "R1 outputs quiet",
        {28'd0, mb_valid, mem_wr_valid, rel_req_valid, done}, 32'd0);
    run_op(0, 32'h8004_5ABC, 32'h100, 0, '0, 0, 0);
    chk(n_rel == 0, "R1 table empty, no relocation", n_rel, 0);
  endtask

  task automatic t_pass;
    run_op(0, 32'h8000_1234, 32'h400, 32'h4, '0, 0, 0);
    chk(r_fin && cyc == 2, "R2 done latency", cyc, 2);
    chk(r_done == 32'h8000_1234 && !r_healed, "R2 unchanged ref", r_done, 32'h8000_1234);
    chk(n_mb == 0 && n_wr == 0 && n_rel == 0, "R2 no side effects", n_mb + n_wr + n_rel, 0);
  endtask

  task automatic t_mark;
    run_op(0, 32'h0000_5678, 32'h1000, 32'h8, '0, 2, 0);
    chk(n_mb == 1 && r_mb == 32'h8000_5678, "R3 mark hand-off value", r_mb, 32'h8000_5678);
    chk(mb_wait == 3, "R3 held until ready", mb_wait, 3);
    chk(n_wr == 1 && r_wa == 32'h1008, "R4 heal address", r_wa, 32'h1008);
    chk(r_wd == 32'h8000_5678, "R4 heal data", r_wd, 32'h8000_5678);
    chk(r_healed && r_done == 32'h8000_5678, "R4 done value", r_done, 32'h8000_5678);
    run_op(0, 32'h0000_0040, 32'hFFFF_FFF0, 32'h20, '0, 0, 0);
    chk(n_wr == 1 && r_wa == 32'h0000_0010, "R4 address wraps", r_wa, 32'h10);
  endtask

  task automatic t_once;
    run_op(0, 32'h8000_5678, 32'h1000, 32'h8, '0, 0, 0);
    chk(n_mb == 0 && n_wr == 0 && !r_healed, "R5 healed value is quiet", n_mb + n_wr, 0);
    mark_phase = 0;
    run_op(0, 32'h8000_5678, 32'h1000, 32'h8, '0, 0, 0);
    chk(n_mb == 1 && r_mb == 32'h0000_5678, "R5 new phase marks again", r_mb, 32'h0000_5678);
    chk(n_wr == 1 && r_wd == 32'h0000_5678, "R5 new phase heal", r_wd, 32'h0000_5678);
    mark_phase = 1;
  endtask

  task automatic t_reloc;
    set_page(0, 19'h00045, 1);
    set_page(2, 19'h7FFFF, 1);
    run_op(0, 32'h8004_5ABC, 32'h2000, 32'h10, 31'h0123_4ABC, 1, 0);
    chk(n_rel == 1 && r_rel == 31'h0004_5ABC, "R6 old address out", {1'b0, r_rel}, 32'h0004_5ABC);
    chk(n_mb == 0, "R7 flag kept, no mark", n_mb, 0);
    chk(n_wr == 1 && r_wa == 32'h2010 && r_wd == 32'h8123_4ABC, "R7 heal to source", r_wd, 32'h8123_4ABC);
    chk(r_healed && r_done == 32'h8123_4ABC, "R7 done value", r_done, 32'h8123_4ABC);
  endtask

  task automatic t_both;
    run_op(0, 32'h0004_5A00, 32'h3000, 32'h0, 31'h0222_2A00, 0, 0);
    chk(n_rel == 1 && n_mb == 1 && rel_it < mb_it, "R8 relocation before mark", rel_it, mb_it);
    chk(r_mb == 32'h8222_2A00, "R8 mark uses remapped ref", r_mb, 32'h8222_2A00);
    chk(n_wr == 1 && r_wd == 32'h8222_2A00, "R8 single heal write", r_wd, 32'h8222_2A00);
  endtask

  task automatic t_access;
    run_op(1, 32'h7FFF_F010, 32'h5000, 32'h4, 31'h0333_3010, 0, 0);
    chk(n_rel == 1 && r_rel == 31'h7FFF_F010, "R9 fault lookup", {1'b0, r_rel}, 32'h7FFF_F010);
    chk(n_mb == 0 && n_wr == 0, "R9 no memory or mark", n_mb + n_wr, 0);
    chk(r_healed && r_done == 32'h0333_3010, "R9 register fix", r_done, 32'h0333_3010);
    run_op(1, 32'h0001_0000, 32'h5000, 32'h4, '0, 0, 0);
    chk(!r_healed && r_done == 32'h0001_0000 && n_mb + n_wr + n_rel == 0, "R9 unprotected fault", r_done, 32'h0001_0000);
  endtask

  task automatic t_clear;
    set_page(0, 19'h00045, 0);
    run_op(0, 32'h8004_5ABC, 32'h2000, 32'h10, '0, 0, 0);
    chk(n_rel == 0 && !r_healed, "R11 cleared entry", n_rel, 0);
    run_op(0, 32'h8004_5ABC, 32'h2000, 32'h10, '0, 0, 0);
    set_page(1, 19'h00045, 1);
    run_op(0, 32'h8004_5ABC, 32'h2000, 32'h10, 31'h0000_1000, 0, 0);
    chk(n_rel == 1 && r_done == 32'h8000_1000, "R11 other entry sets page", r_done, 32'h8000_1000);
  endtask

  task automatic t_busy;
    run_op(0, 32'h0000_7770, 32'h6000, 32'h0, '0, 3, 1);
    chk(busy_bad == 0, "R10 not ready while busy", busy_bad, 0);
    chk(n_mb == 1 && r_mb == 32'h8000_7770, "R10 intruder ignored (mark)", r_mb, 32'h8000_7770);
    chk(n_wr == 1 && r_wa == 32'h6000, "R10 intruder ignored (write)", r_wa, 32'h6000);
    chk(!busy, "R10 idle after done", {31'd0, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_mark();
    t_once();
    t_reloc();
    t_both();
    t_access();
    t_clear();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule